// File: doc/BRIEF.md
# Potentiometer Command Executor

This block carries out the instruction stream that reaches a dual digital potentiometer once a framing layer has recognised a START, an address match, the received bytes and a STOP. It keeps one volatile 8-bit wiper code per channel and four preset registers per channel that model nonvolatile storage. It reads and writes either kind of register and copies presets into wipers or wipers into presets, for one channel or for both at once. It also has a stepping mode in which each step pulse moves a wiper up or down by one code.

Every write into a preset register is held back until the STOP of its frame. The preset then changes and a program interval of `PROG_CYCLES` clock cycles starts, during which the block reports busy and ignores every new frame. An active-low write-protect input cancels a pending preset write if it is seen low at any point between START and STOP. Wiper writes are never blocked by it. After reset each wiper takes the value of preset 0 of its own channel.

Top module: `pot_cmd_exec`

## Requirements
- R1: During reset both wiper codes are 0 and busy is low. On the first clock after the internal reset releases, each wiper is loaded from preset 0 of its channel (defaults 0x40 for channel 0 and 0xC0 for channel 1).
- R2: The instruction byte is opcode[7:4], preset select[3:2], channel select[1:0]. Opcode 1001 returns the selected wiper and opcode 1011 returns the selected preset on rd_data, with rd_valid high for the one cycle after the instruction byte. A channel select of 2 or 3 returns 0.
- R3: Opcode 1010 followed by a data byte sets the selected wiper to that byte in the cycle after the data byte, whatever the level of wp_n.
- R4: Opcode 1100 followed by a data byte changes the selected preset only at STOP. Busy is then high for exactly PROG_CYCLES cycles, starting in the cycle after STOP.
- R5: Opcode 1101 copies the selected preset of the selected channel into its wiper, and opcode 0001 copies preset R of both channels into both wipers. Either takes effect in the cycle after the instruction byte.
- R6: Opcode 1110 copies the selected wiper into preset R of its channel, and opcode 1000 does this for both channels. Either commits at STOP and starts the busy interval.
- R7: If wp_n is low at the data byte of a 1100 command, that byte is not acknowledged. If wp_n is low in any cycle from START through STOP, no preset changes and busy stays low. A wp_n drop after STOP does not undo the write.
- R8: While busy, START and bytes are ignored: no acknowledge, no read data and no register change.
- R9: After opcode 0010, each step pulse moves the selected wiper one code up when step_up is 1 and one code down when it is 0, saturating at 0x00 and 0xFF.
- R10: A write-type command with channel select 2 or 3 changes no register and starts no busy interval.
- R11: An unknown opcode is acknowledged and then ignored. A following byte is not acknowledged and no register changes.
- R12: Each instruction byte is acknowledged one cycle after it arrives when the block is idle. Any byte after a read or transfer command is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write protect, low blocks preset writes |
| frame_start | input | 1 | One-cycle pulse: addressed frame begins |
| frame_stop | input | 1 | One-cycle pulse: frame ends |
| byte_valid | input | 1 | One-cycle pulse: byte_data holds a received byte |
| byte_data | input | 8 | Received instruction or data byte |
| step_valid | input | 1 | One-cycle step pulse in stepping mode |
| step_up | input | 1 | Step direction, 1 up, 0 down |
| byte_ack | output | 1 | Acknowledge for the byte of the previous cycle |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 8 | Read result |
| busy | output | 1 | Program interval in progress |
| wiper_codes | output | 16 | Wiper codes, channel c in bits [8c+7:8c] |

## Verification
The checker watches several rules on every cycle. Presets may change only in the cycle after a STOP and never after a STOP seen with write protect low. Busy may rise only after a STOP. No byte is acknowledged while busy. The reset recall copies preset 0 into wiper 0, and an up step while stepping adds exactly one to wiper 0. Other behaviour shows only in the bench's scenarios: read values, the exact length of the busy interval, write protect dropping in the middle of a frame, gang transfers, saturation at both ends and the rejection of invalid channels and unknown opcodes.

// File: rtl/pot_pkg.sv
package pot_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    K_NONE, K_RD_W, K_WR_W, K_RD_D, K_WR_D,
    K_D2W, K_W2D, K_GD2W, K_GW2D, K_STEP
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] rsel;
    logic [1:0] psel;
  } cmd_t;

  typedef enum logic [2:0] {
    S_RECALL, S_IDLE, S_INSTR, S_DATA, S_STEP, S_TAIL
  } state_e;
endpackage

// File: rtl/pot_decode.sv
module pot_decode
  import pot_pkg::*;
(
  input  logic [7:0] instr,
  output cmd_t       cmd
);
  always_comb begin
    cmd.rsel = instr[3:2];
    cmd.psel = instr[1:0];
    case (instr[7:4])
      4'b1001: cmd.kind = K_RD_W;
      4'b1010: cmd.kind = K_WR_W;
      4'b1011: cmd.kind = K_RD_D;
      4'b1100: cmd.kind = K_WR_D;
      4'b1101: cmd.kind = K_D2W;
      4'b1110: cmd.kind = K_W2D;
      4'b0001: cmd.kind = K_GD2W;
      4'b1000: cmd.kind = K_GW2D;
      4'b0010: cmd.kind = K_STEP;
      default: cmd.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/pot_regs.sv
module pot_regs #(
  parameter int NCH = 2,
  parameter int NDR = 4,
  parameter int DW  = 8,
  parameter logic [NCH*NDR*DW-1:0] PRESET = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH-1:0]                wip_we,
  input  logic [NCH-1:0][DW-1:0]        wip_wd,
  input  logic [NCH-1:0]                dr_we,
  input  logic [1:0]                    dr_idx,
  input  logic [NCH-1:0][DW-1:0]        dr_wd,
  output logic [NCH-1:0][DW-1:0]        wip_q,
  output logic [NCH-1:0][NDR-1:0][DW-1:0] dr_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wip_q[c] <= '0;
      else if (wip_we[c]) wip_q[c] <= wip_wd[c];
    end
    for (genvar r = 0; r < NDR; r++) begin : g_dr
      logic hit;
      assign hit = dr_we[c] && (int'(dr_idx) == r);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dr_q[c][r] <= PRESET[(c*NDR+r)*DW +: DW];
        else if (hit) dr_q[c][r] <= dr_wd[c];
      end
    end
  end
endmodule

// File: rtl/pot_prog_timer.sv
module pot_prog_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = CW'(CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/pot_cmd_exec.sv
module pot_cmd_exec
  import pot_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int NDR         = 4,
  parameter int PROG_CYCLES = 8,
  parameter logic [NCH*NDR*DATA_W-1:0] PRESET = 64'h3322_11C0_3020_1040
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wp_n,
  input  logic                  frame_start,
  input  logic                  frame_stop,
  input  logic                  byte_valid,
  input  logic [7:0]            byte_data,
  input  logic                  step_valid,
  input  logic                  step_up,
  output logic                  byte_ack,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  busy,
  output logic [NCH*DATA_W-1:0] wiper_codes
);
  localparam int DW = DATA_W;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  state_e state_q, state_d;
  cmd_t   cmd_q, cmd_d, dec;
  logic   pend_q, pend_d, wpx_q, wpx_d;
  logic   ack_d, rdv_d, commit;
  logic [DW-1:0] pdata_q, pdata_d, rdd_d, sel_w, sel_d;

  logic [NCH-1:0]                  wip_we, dr_we;
  logic [NCH-1:0][DW-1:0]          wip_wd, dr_wd, wip_q;
  logic [NCH-1:0][NDR-1:0][DW-1:0] dr_q;

  pot_decode u_dec (.instr(byte_data), .cmd(dec));

  pot_regs #(.NCH(NCH), .NDR(NDR), .DW(DW), .PRESET(PRESET)) u_regs (
    .clk(clk), .rst_n(rst_i), .wip_we(wip_we), .wip_wd(wip_wd),
    .dr_we(dr_we), .dr_idx(cmd_q.rsel), .dr_wd(dr_wd),
    .wip_q(wip_q), .dr_q(dr_q)
  );

  pot_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_i), .start(commit), .busy(busy)
  );

  // read multiplexers; an absent channel reads as zero
  always_comb begin
    sel_w = '0;
    sel_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (int'(dec.psel) == c) begin
        sel_w = wip_q[c];
        sel_d = dr_q[c][dec.rsel];
      end
    end
  end

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    pend_d  = pend_q;
    pdata_d = pdata_q;
    wpx_d   = wpx_q | (!wp_n && state_q != S_IDLE && state_q != S_RECALL);
    ack_d   = 1'b0;
    rdv_d   = 1'b0;
    rdd_d   = '0;
    commit  = 1'b0;
    wip_we  = '0;
    wip_wd  = wip_q;
    dr_we   = '0;
    dr_wd   = wip_q;
    case (state_q)
      S_RECALL: begin
        for (int c = 0; c < NCH; c++) begin
          wip_we[c] = 1'b1;
          wip_wd[c] = dr_q[c][0];
        end
        state_d = S_IDLE;
      end
      S_IDLE: begin
        if (frame_start && !busy) begin
          state_d = S_INSTR;
          wpx_d   = !wp_n;
          pend_d  = 1'b0;
        end
      end
      S_INSTR: begin
        if (byte_valid) begin
          ack_d   = 1'b1;
          cmd_d   = dec;
          state_d = S_TAIL;
          case (dec.kind)
            K_RD_W: begin rdv_d = 1'b1; rdd_d = sel_w; end
            K_RD_D: begin rdv_d = 1'b1; rdd_d = sel_d; end
            K_WR_W, K_WR_D: state_d = S_DATA;
            K_STEP: state_d = S_STEP;
            K_D2W, K_GD2W: begin
              for (int c = 0; c < NCH; c++) begin
                if (dec.kind == K_GD2W || int'(dec.psel) == c) begin
                  wip_we[c] = 1'b1;
                  wip_wd[c] = dr_q[c][dec.rsel];
                end
              end
            end
            K_W2D:  pend_d = (int'(dec.psel) < NCH);
            K_GW2D: pend_d = 1'b1;
            default: ;
          endcase
        end
      end
      S_DATA: begin
        if (byte_valid) begin
          state_d = S_TAIL;
          if (cmd_q.kind == K_WR_W) begin
            ack_d = 1'b1;
            for (int c = 0; c < NCH; c++) begin
              if (int'(cmd_q.psel) == c) begin
                wip_we[c] = 1'b1;
                wip_wd[c] = byte_data;
              end
            end
          end else if (!(wpx_q || !wp_n)) begin
            ack_d   = 1'b1;
            pend_d  = (int'(cmd_q.psel) < NCH);
            pdata_d = byte_data;
          end
        end
      end
      S_STEP: begin
        if (step_valid) begin
          for (int c = 0; c < NCH; c++) begin
            if (int'(cmd_q.psel) == c) begin
              wip_we[c] = 1'b1;
              if (step_up) wip_wd[c] = (wip_q[c] == '1) ? wip_q[c] : wip_q[c] + 1'b1;
              else         wip_wd[c] = (wip_q[c] == '0) ? wip_q[c] : wip_q[c] - 1'b1;
            end
          end
        end
      end
      default: ;
    endcase

    if (frame_stop && state_q != S_IDLE && state_q != S_RECALL) begin
      state_d = S_IDLE;
      pend_d  = 1'b0;
      if (pend_q && !wpx_q && wp_n) begin
        commit = 1'b1;
        for (int c = 0; c < NCH; c++) begin
          if (cmd_q.kind == K_GW2D || int'(cmd_q.psel) == c) begin
            dr_we[c] = 1'b1;
            dr_wd[c] = (cmd_q.kind == K_WR_D) ? pdata_q : wip_q[c];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q  <= S_RECALL;
      cmd_q    <= '0;
      pend_q   <= 1'b0;
      pdata_q  <= '0;
      wpx_q    <= 1'b0;
      byte_ack <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      pend_q   <= pend_d;
      pdata_q  <= pdata_d;
      wpx_q    <= wpx_d;
      byte_ack <= ack_d;
      rd_valid <= rdv_d;
      rd_data  <= rdd_d;
    end
  end

  assign wiper_codes = wip_q;
endmodule

// File: rtl/pot_cmd_exec_chk.sv
module pot_cmd_exec_chk
  import pot_pkg::*;
#(
  parameter int NCH = 2,
  parameter int NDR = 4,
  parameter int DW  = 8
) (
  input logic                          clk,
  input logic                          rst_i,
  input logic                          wp_n,
  input logic                          frame_stop,
  input logic                          byte_valid,
  input logic                          step_valid,
  input logic                          step_up,
  input logic                          byte_ack,
  input logic                          busy,
  input state_e                        state,
  input logic [1:0]                    psel,
  input logic [NCH*DW-1:0]             wiper_codes,
  input logic [NCH-1:0][NDR-1:0][DW-1:0] dr_q
);
  assert_recall_R1: assert property (@(posedge clk) disable iff (!rst_i)
    (state == S_RECALL) |=> (wiper_codes[DW-1:0] == $past(dr_q[0][0])));

  assert_preset_only_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_i)
    !frame_stop |=> $stable(dr_q));

  assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(busy) |-> $past(frame_stop));

  assert_wp_blocks_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (frame_stop && !wp_n) |=> $stable(dr_q));

  assert_busy_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && byte_valid) |=> !byte_ack);

  assert_step_up_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (state == S_STEP && step_valid && step_up && psel == 2'd0 &&
     wiper_codes[DW-1:0] != '1 && !frame_stop)
    |=> (wiper_codes[DW-1:0] == $past(wiper_codes[DW-1:0]) + 1'b1));
endmodule

bind pot_cmd_exec pot_cmd_exec_chk #(.NCH(NCH), .NDR(NDR), .DW(DW)) u_chk (
  .clk(clk), .rst_i(rst_i), .wp_n(wp_n), .frame_stop(frame_stop),
  .byte_valid(byte_valid), .step_valid(step_valid), .step_up(step_up),
  .byte_ack(byte_ack), .busy(busy), .state(state_q), .psel(cmd_q.psel),
  .wiper_codes(wiper_codes), .dr_q(dr_q)
);

// File: tb/sim_pot_cmd_exec.sv
module sim_pot_cmd_exec;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 8;

  logic clk = 1'b0;
  logic rst_n, wp_n, frame_start, frame_stop, byte_valid, step_valid, step_up;
  logic [7:0] byte_data;
  logic byte_ack, rd_valid, busy;
  logic [7:0] rd_data;
  logic [15:0] wiper_codes;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pot_cmd_exec #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .frame_start(frame_start),
    .frame_stop(frame_stop), .byte_valid(byte_valid), .byte_data(byte_data),
    .step_valid(step_valid), .step_up(step_up), .byte_ack(byte_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .wiper_codes(wiper_codes)
  );

  function automatic logic [7:0] wip(int c);
    return wiper_codes[c*8 +: 8];
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read results against expected queue
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2/R8 unexpected read actual=0x%0h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rd_data != e) begin
          n_fail++;
          $display("FAIL R2 read actual=0x%0h expected=0x%0h", rd_data, e);
        end
      end
    end
  end

  task automatic start();
    frame_start = 1'b1; @(posedge clk); @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic stop();
    frame_stop = 1'b1; @(posedge clk); @(negedge clk); frame_stop = 1'b0;
  endtask

  task automatic send(string tag, logic [7:0] b, logic exp_ack);
    byte_data = b; byte_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    byte_valid = 1'b0;
    check(tag, byte_ack, exp_ack);
  endtask

  task automatic step(string tag, logic up, int ch, int exp);
    step_up = up; step_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    step_valid = 1'b0;
    check(tag, wip(ch), exp);
  endtask

  // driver for reads: push expected, issue frame
  task automatic rd(string tag, logic [7:0] instr, logic [7:0] exp);
    exp_q.push_back(exp);
    start(); send(tag, instr, 1'b1); stop();
  endtask

  task automatic wr(string tag, logic [7:0] instr, logic [7:0] d, logic dack);
    start(); send(tag, instr, 1'b1); send(tag, d, dack); stop();
  endtask

  task automatic wait_idle(string tag, int exp_n);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(tag, n, exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wp_n = 1'b1; frame_start = 1'b0; frame_stop = 1'b0;
    byte_valid = 1'b0; byte_data = '0; step_valid = 1'b0; step_up = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset wiper0", wip(0), 0);
    check("R1 reset wiper1", wip(1), 0);
    check("R1 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 recall wiper0", wip(0), 8'h40);
    check("R1 recall wiper1", wip(1), 8'hC0);

    // R2 reads; R12 trailing byte not acked
    exp_q.push_back(8'h22);
    start(); send("R2 read preset ack", 8'hB9, 1'b1);
    send("R12 byte after read", 8'hFF, 1'b0); stop();
    rd("R2 read wiper", 8'h90, 8'h40);

    // R3 wiper write with protect low
    wp_n = 1'b0;
    start(); send("R3 instr", 8'hA1, 1'b1); send("R3 data ack", 8'h5A, 1'b1);
    check("R3 wiper1 written", wip(1), 8'h5A); stop();
    wp_n = 1'b1;

    // R4 preset write, busy interval
    wr("R4 write", 8'hC4, 8'h77, 1'b1);
    wait_idle("R4 busy length", PROG);
    rd("R4 readback", 8'hB4, 8'h77);

    // R8 ignored while busy
    wr("R8 write", 8'hC9, 8'h66, 1'b1);
    start(); send("R8 byte while busy", 8'h90, 1'b0); stop();
    wait_idle("R8 busy remainder", PROG - 3);
    rd("R8 readback", 8'hB9, 8'h66);

    // R5 preset to wiper
    start(); send("R5 single", 8'hD4, 1'b1);
    check("R5 single wiper0", wip(0), 8'h77); stop();
    start(); send("R5 gang", 8'h18, 1'b1);
    check("R5 gang wiper0", wip(0), 8'h20);
    check("R5 gang wiper1", wip(1), 8'h66); stop();

    // R6 wiper to preset
    start(); send("R6 single", 8'hED, 1'b1); stop();
    wait_idle("R6 single busy", PROG);
    rd("R6 single readback", 8'hBD, 8'h66);
    start(); send("R6 gang", 8'h80, 1'b1); stop();
    wait_idle("R6 gang busy", PROG);
    rd("R6 gang ch0", 8'hB0, 8'h20);
    rd("R6 gang ch1", 8'hB1, 8'h66);

    // R7 write protect
    wp_n = 1'b0;
    wr("R7 protected data nack", 8'hC8, 8'h99, 1'b0);
    check("R7 no busy", busy, 0);
    wp_n = 1'b1;
    rd("R7 preset kept", 8'hB8, 8'h20);
    start(); send("R7 transfer", 8'hEC, 1'b1);
    wp_n = 1'b0; @(negedge clk); wp_n = 1'b1;
    stop();
    check("R7 cancelled no busy", busy, 0);
    rd("R7 cancelled kept", 8'hBC, 8'h30);
    wr("R7 late drop", 8'hC5, 8'h5C, 1'b1);
    wp_n = 1'b0;
    wait_idle("R7 late drop busy", PROG);
    wp_n = 1'b1;
    rd("R7 late drop committed", 8'hB5, 8'h5C);

    // R9 stepping
    start(); send("R9 enter", 8'h20, 1'b1);
    step("R9 up1", 1'b1, 0, 8'h21);
    step("R9 up2", 1'b1, 0, 8'h22);
    step("R9 up3", 1'b1, 0, 8'h23);
    step("R9 down", 1'b0, 0, 8'h22); stop();
    wr("R9 set", 8'hA1, 8'hFE, 1'b1);
    start(); send("R9 enter1", 8'h21, 1'b1);
    step("R9 to top", 1'b1, 1, 8'hFF);
    step("R9 sat top", 1'b1, 1, 8'hFF); stop();
    wr("R9 set0", 8'hA0, 8'h01, 1'b1);
    start(); send("R9 enter0", 8'h20, 1'b1);
    step("R9 to zero", 1'b0, 0, 8'h00);
    step("R9 sat zero", 1'b0, 0, 8'h00); stop();

    // R10 invalid channel; R2 invalid read
    wr("R10 wiper write", 8'hA2, 8'h12, 1'b1);
    check("R10 wiper0 kept", wip(0), 8'h00);
    check("R10 wiper1 kept", wip(1), 8'hFF);
    rd("R2 invalid channel read", 8'h92, 8'h00);
    wr("R10 preset write", 8'hC2, 8'h12, 1'b1);
    check("R10 no busy", busy, 0);

    // R11 unknown opcode
    start(); send("R11 ack", 8'h30, 1'b1); send("R11 data nack", 8'h55, 1'b0); stop();
    check("R11 wiper0 kept", wip(0), 8'h00);
    check("R11 wiper1 kept", wip(1), 8'hFF);
    check("R11 no busy", busy, 0);

    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule